// File: doc/BRIEF.md
# Adaptive Router Input Controller

This block is the input-side controller of a mesh router. The router has four neighbour ports (north, east, south, west) and one local port. Each input port holds one packet header at a time. The controller visits the five input ports in a fixed rotating order, one port per controller cycle, so every port is seen once in five cycles. For the header it is visiting, it reads the destination coordinates and the switching kind. It then picks an output on a minimal path and reports the grant, which also updates the crossbar select for that output. An input that has no usable output is told to hold its packet, and it keeps the packet until a later visit finds a path.

The set of usable outputs changes while the router runs. Each neighbour controller sends the block a stream of side-band messages. A reserve message excludes the direction toward that neighbour, and a release message brings it back. A neighbour that sends nothing for a programmable number of cycles is treated as failed and excluded. Any message from it restores it.

A header that opens a circuit pins its output to its own input. The output stays pinned until an end-of-transmission header from the same input passes through it. The block tells its neighbours about each pin and each unpin on its own outgoing message channel. When the preferred direction is excluded, the packet takes the other productive direction if that one is usable. Packets are never queued beyond the single buffer at each port.

Top module: `adaptive_input_ctrl`

## Requirements
- R1: Directions are encoded N=0, E=1, S=2, W=3, Local=4. North means a larger y and east means a larger x than the router's own coordinates. If the destination x differs from the router's x, the east/west direction is preferred. Otherwise the north/south direction is used. If both coordinates match, the packet goes to Local.
- R2: Ports are visited in the order 0,1,2,3,4,0,... at one port per cycle. A port that holds a valid header and finds a usable output gets a one-cycle `hdr_pop` pulse. In the same cycle `gnt_valid` is set, `gnt_in`/`gnt_out` name the input and output, and the `xbar_sel` field of that output equals the input index.
- R3: Header kind encoding is 0=packet, 1=circuit-open and 2=end-of-transmission. A granted circuit-open header sets the `xbar_hold` bit of its output. In the grant cycle, `ctl_kind` carries reserve (1).
- R4: An output whose `xbar_hold` bit is set is granted only to the input that pinned it. That input may keep sending headers of any kind through it.
- R5: An end-of-transmission header that the pinning input sends through its pinned output clears the hold bit. In the grant cycle, `ctl_kind` carries release (2). After that, other inputs can be granted that output.
- R6: Neighbour message kinds are 0=heartbeat, 1=reserve and 2=release. A reserve excludes that neighbour's direction until a release arrives. A message applies to a port visit in the same cycle it arrives.
- R7: A neighbour that sends no message for `live_limit` consecutive cycles is excluded from routing. The next message of any kind restores it.
- R8: When the preferred direction is excluded, the header is granted the other productive direction, provided that direction is usable.
- R9: When no productive output is usable, there is no grant and no pop. `in_ready` of that port goes low from that visit until the port is granted or its valid drops.
- R10: While reset is asserted, `in_ready` is all ones and `hdr_pop`, `gnt_valid`, `xbar_hold` and `ctl_valid` are zero. From the first cycle after reset, `ctl_valid` is 1 and `ctl_kind` is heartbeat (0) when there is no pin or unpin to report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hdr_valid | input | 5 | Header present in each input buffer |
| hdr_dest_x | input | 5*COORD_W | Destination x per input port |
| hdr_dest_y | input | 5*COORD_W | Destination y per input port |
| hdr_kind | input | 10 | Switching kind per input port, 2 bits each |
| in_ready | output | 5 | Low while a port's header has no usable path |
| hdr_pop | output | 5 | One-cycle pulse: header of that port granted |
| nbr_msg_valid | input | 4 | Side-band message strobe per neighbour |
| nbr_msg_kind | input | 8 | Side-band message kind per neighbour, 2 bits each |
| live_limit | input | TMO_W | Silent cycles after which a neighbour counts as failed |
| ctl_valid | output | 1 | Outgoing side-band message valid |
| ctl_kind | output | 2 | Outgoing side-band message kind |
| gnt_valid | output | 1 | A grant was made in this cycle |
| gnt_in | output | 3 | Granted input port |
| gnt_out | output | 3 | Granted output port |
| xbar_sel | output | 15 | Crossbar source index per output, 3 bits each |
| xbar_hold | output | 5 | Output pinned to a circuit |

## Verification
Two functions can fall in the same cycle. A neighbour reserve message can arrive in exactly the cycle the controller visits a port whose preferred direction is that neighbour. The bench learns the visiting phase of the local port from an earlier grant, then pulses the reserve message exactly five cycles later together with a fresh header. The result is judged by the granted output: the alternate direction shows that the message took effect in that visit, while the preferred direction would show that it was missed.

// File: rtl/ric_pkg.sv
// Shared constants and encodings for the adaptive router input controller.
// Assumes a fixed five-port router: four mesh neighbours plus one local port.
package ric_pkg;
    localparam int NPORT  = 5;
    localparam int NNBR   = 4;
    localparam int PIDX_W = 3;

    localparam logic [PIDX_W-1:0] DIR_N = 3'd0;
    localparam logic [PIDX_W-1:0] DIR_E = 3'd1;
    localparam logic [PIDX_W-1:0] DIR_S = 3'd2;
    localparam logic [PIDX_W-1:0] DIR_W = 3'd3;
    localparam logic [PIDX_W-1:0] DIR_L = 3'd4;

    typedef enum logic [1:0] {
        HK_PACKET  = 2'd0,
        HK_CIRCUIT = 2'd1,
        HK_END     = 2'd2,
        HK_SPARE   = 2'd3
    } hdr_kind_e;

    typedef enum logic [1:0] {
        NM_BEAT    = 2'd0,
        NM_RESERVE = 2'd1,
        NM_RELEASE = 2'd2,
        NM_SPARE   = 2'd3
    } nbr_msg_e;
endpackage

// File: rtl/ric_nbr_state.sv
// Routing-table entry for one neighbour: liveness and reservation state.
// A neighbour is usable when it has not been silent for live_limit cycles
// and has not reserved the path. The next-state value is exported so that
// a message arriving in a cycle affects the port visit of that same cycle.
module ric_nbr_state
    import ric_pkg::*;
#(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             msg_valid,
    input  logic [1:0]       msg_kind,
    input  logic [TMO_W-1:0] live_limit,
    output logic             usable_nx
);
    logic [TMO_W-1:0] silent_q, silent_nx;
    logic             block_q, block_nx;
    logic             alive_nx;

    // Next-state of the silence counter, reservation flag and usability.
    always_comb begin
        if (msg_valid)
            silent_nx = '0;
        else if (silent_q >= live_limit)
            silent_nx = silent_q;
        else
            silent_nx = silent_q + 1'b1;

        block_nx = block_q;
        if (msg_valid && nbr_msg_e'(msg_kind) == NM_RESERVE)
            block_nx = 1'b1;
        else if (msg_valid && nbr_msg_e'(msg_kind) == NM_RELEASE)
            block_nx = 1'b0;

        alive_nx  = msg_valid || (silent_nx < live_limit);
        usable_nx = alive_nx && !block_nx;
    end

    // Register silence count and reservation flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            silent_q <= '0;
            block_q  <= 1'b0;
        end else begin
            silent_q <= silent_nx;
            block_q  <= block_nx;
        end
    end
endmodule

// File: rtl/ric_route.sv
// Minimal-path output selection for one header. The east/west direction is
// preferred over north/south. If the preferred direction is unavailable, the
// other productive direction is tried. A local destination needs the local
// output. This is pure combinational logic.
module ric_route
    import ric_pkg::*;
#(
    parameter int COORD_W = 3,
    parameter int MY_X    = 2,
    parameter int MY_Y    = 2
) (
    input  logic [COORD_W-1:0] dest_x,
    input  logic [COORD_W-1:0] dest_y,
    input  logic [NPORT-1:0]   avail,
    output logic               found,
    output logic [PIDX_W-1:0]  dir
);
    localparam logic [COORD_W-1:0] HOME_X = COORD_W'(MY_X);
    localparam logic [COORD_W-1:0] HOME_Y = COORD_W'(MY_Y);

    logic              x_need, y_need;
    logic [PIDX_W-1:0] x_dir, y_dir;

    // Pick the first usable productive direction.
    always_comb begin
        x_need = (dest_x != HOME_X);
        y_need = (dest_y != HOME_Y);
        x_dir  = (dest_x > HOME_X) ? DIR_E : DIR_W;
        y_dir  = (dest_y > HOME_Y) ? DIR_N : DIR_S;
        found  = 1'b0;
        dir    = DIR_L;
        if (!x_need && !y_need) begin
            found = avail[DIR_L];
        end else if (x_need && avail[x_dir]) begin
            found = 1'b1;
            dir   = x_dir;
        end else if (y_need && avail[y_dir]) begin
            found = 1'b1;
            dir   = y_dir;
        end
    end
endmodule

// File: rtl/adaptive_input_ctrl.sv
// Input controller of a five-port router. It visits the input buffers in a
// fixed rotation, one per cycle, and routes the visited header over an
// adaptive table. It grants the output, pins outputs for circuits, and
// reports pins and unpins to the neighbours. Assumes a header stays valid
// until it is popped.
module adaptive_input_ctrl
    import ric_pkg::*;
#(
    parameter int COORD_W = 3,
    parameter int MY_X    = 2,
    parameter int MY_Y    = 2,
    parameter int TMO_W   = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NPORT-1:0]           hdr_valid,
    input  logic [NPORT*COORD_W-1:0]   hdr_dest_x,
    input  logic [NPORT*COORD_W-1:0]   hdr_dest_y,
    input  logic [NPORT*2-1:0]         hdr_kind,
    output logic [NPORT-1:0]           in_ready,
    output logic [NPORT-1:0]           hdr_pop,
    input  logic [NNBR-1:0]            nbr_msg_valid,
    input  logic [NNBR*2-1:0]          nbr_msg_kind,
    input  logic [TMO_W-1:0]           live_limit,
    output logic                       ctl_valid,
    output logic [1:0]                 ctl_kind,
    output logic                       gnt_valid,
    output logic [PIDX_W-1:0]          gnt_in,
    output logic [PIDX_W-1:0]          gnt_out,
    output logic [NPORT*PIDX_W-1:0]    xbar_sel,
    output logic [NPORT-1:0]           xbar_hold
);
    localparam logic [PIDX_W-1:0] LAST_PORT = PIDX_W'(NPORT - 1);

    logic [PIDX_W-1:0]  scan_q;
    logic [PIDX_W-1:0]  sel_q [NPORT];
    logic [NPORT-1:0]   hold_q, ready_q, pop_q;
    logic               gnt_valid_q, ctl_valid_q;
    logic [PIDX_W-1:0]  gnt_in_q, gnt_out_q;
    nbr_msg_e           ctl_kind_q;

    logic               cur_valid;
    logic [COORD_W-1:0] cur_x, cur_y;
    hdr_kind_e          cur_kind;
    logic [NNBR-1:0]    nbr_usable;
    logic [NPORT-1:0]   res_ok, avail;
    logic               rt_found;
    logic [PIDX_W-1:0]  rt_dir;
    logic               do_grant, do_unpin;

    // One routing-table entry per neighbour direction.
    for (genvar d = 0; d < NNBR; d++) begin : g_nbr
        ric_nbr_state #(.TMO_W(TMO_W)) u_nbr (
            .clk        (clk),
            .rst_n      (rst_n),
            .msg_valid  (nbr_msg_valid[d]),
            .msg_kind   (nbr_msg_kind[d*2 +: 2]),
            .live_limit (live_limit),
            .usable_nx  (nbr_usable[d])
        );
    end

    // An output is open to the visited port unless it is pinned by another.
    for (genvar o = 0; o < NPORT; o++) begin : g_out
        assign res_ok[o] = !hold_q[o] || (sel_q[o] == scan_q);
        if (o < NNBR) begin : g_mesh
            assign avail[o] = res_ok[o] && nbr_usable[o];
        end else begin : g_local
            assign avail[o] = res_ok[o];
        end
        assign xbar_sel[o*PIDX_W +: PIDX_W] = sel_q[o];
    end

    // Select the header fields of the port visited this cycle.
    always_comb begin
        cur_valid = 1'b0;
        cur_x     = '0;
        cur_y     = '0;
        cur_kind  = HK_PACKET;
        for (int p = 0; p < NPORT; p++) begin
            if (scan_q == PIDX_W'(p)) begin
                cur_valid = hdr_valid[p];
                cur_x     = hdr_dest_x[p*COORD_W +: COORD_W];
                cur_y     = hdr_dest_y[p*COORD_W +: COORD_W];
                cur_kind  = hdr_kind_e'(hdr_kind[p*2 +: 2]);
            end
        end
    end

    ric_route #(.COORD_W(COORD_W), .MY_X(MY_X), .MY_Y(MY_Y)) u_route (
        .dest_x (cur_x),
        .dest_y (cur_y),
        .avail  (avail),
        .found  (rt_found),
        .dir    (rt_dir)
    );

    assign do_grant = cur_valid && rt_found;
    assign do_unpin = do_grant && (cur_kind == HK_END) && hold_q[rt_dir];

    // Advance the rotating visit pointer.
    always_ff @(posedge clk) begin
        if (!rst_n)
            scan_q <= '0;
        else
            scan_q <= (scan_q == LAST_PORT) ? '0 : scan_q + 1'b1;
    end

    // Register the grant report and the pop pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt_valid_q <= 1'b0;
            gnt_in_q    <= '0;
            gnt_out_q   <= '0;
            pop_q       <= '0;
        end else begin
            gnt_valid_q <= do_grant;
            pop_q       <= '0;
            if (do_grant) begin
                gnt_in_q      <= scan_q;
                gnt_out_q     <= rt_dir;
                pop_q[scan_q] <= 1'b1;
            end
        end
    end

    // Track per-port readiness: drop on a blocked visit, raise on grant or idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ready_q <= '1;
        else
            ready_q[scan_q] <= !cur_valid || rt_found;
    end

    // Update the crossbar select and the circuit pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            for (int o = 0; o < NPORT; o++) sel_q[o] <= '0;
        end else if (do_grant) begin
            sel_q[rt_dir] <= scan_q;
            if (cur_kind == HK_CIRCUIT)
                hold_q[rt_dir] <= 1'b1;
            else if (do_unpin)
                hold_q[rt_dir] <= 1'b0;
        end
    end

    // Drive the outgoing side-band message: pin, unpin or heartbeat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_valid_q <= 1'b0;
            ctl_kind_q  <= NM_BEAT;
        end else begin
            ctl_valid_q <= 1'b1;
            if (do_grant && cur_kind == HK_CIRCUIT)
                ctl_kind_q <= NM_RESERVE;
            else if (do_unpin)
                ctl_kind_q <= NM_RELEASE;
            else
                ctl_kind_q <= NM_BEAT;
        end
    end

    assign in_ready  = ready_q;
    assign hdr_pop   = pop_q;
    assign gnt_valid = gnt_valid_q;
    assign gnt_in    = gnt_in_q;
    assign gnt_out   = gnt_out_q;
    assign xbar_hold = hold_q;
    assign ctl_valid = ctl_valid_q;
    assign ctl_kind  = ctl_kind_q;
endmodule

// File: rtl/adaptive_input_ctrl_chk.sv
// Property checker for the adaptive router input controller. It observes the
// top-level ports only and is attached to the top module by bind.
module adaptive_input_ctrl_chk
    import ric_pkg::*;
(
    input logic                    clk,
    input logic                    rst_n,
    input logic [NPORT-1:0]        hdr_valid,
    input logic [NPORT-1:0]        hdr_pop,
    input logic [NPORT-1:0]        in_ready,
    input logic                    gnt_valid,
    input logic [PIDX_W-1:0]       gnt_in,
    input logic [PIDX_W-1:0]       gnt_out,
    input logic [NPORT*PIDX_W-1:0] xbar_sel,
    input logic [NPORT-1:0]        xbar_hold,
    input logic                    ctl_valid,
    input logic [1:0]              ctl_kind
);
    // R2: at most one port is popped per cycle.
    a_r2_single_pop: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hdr_pop));

    // R2: a grant is only made to a port that held a valid header.
    a_r2_grant_had_header: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> (($past(hdr_valid) & (5'b1 << gnt_in)) != 5'b0));

    // R3: a newly pinned output is announced with a reserve message.
    a_r3_pin_announced: assert property (@(posedge clk) disable iff (!rst_n)
        ((xbar_hold & ~$past(xbar_hold)) != 5'b0) |-> (ctl_kind == 2'd1));

    // R5: a freed output is announced with a release message.
    a_r5_unpin_announced: assert property (@(posedge clk) disable iff (!rst_n)
        ((~xbar_hold & $past(xbar_hold)) != 5'b0) |-> (ctl_kind == 2'd2));

    // R10: the outgoing message channel is valid once out of reset.
    a_r10_ctl_live: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ctl_valid);

    for (genvar o = 0; o < NPORT; o++) begin : g_own
        // R4: a pinned output is granted only to its owner.
        a_r4_pinned_owner: assert property (@(posedge clk) disable iff (!rst_n)
            (gnt_valid && gnt_out == PIDX_W'(o) && $past(xbar_hold[o]))
            |-> (gnt_in == $past(xbar_sel[o*PIDX_W +: PIDX_W])));
    end

    for (genvar i = 0; i < NPORT; i++) begin : g_rdy
        // R9: readiness only falls for a port holding an ungranted header.
        a_r9_ready_fall: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(in_ready[i]) |-> ($past(hdr_valid[i]) && !hdr_pop[i]));
    end
endmodule

bind adaptive_input_ctrl adaptive_input_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hdr_valid (hdr_valid),
    .hdr_pop   (hdr_pop),
    .in_ready  (in_ready),
    .gnt_valid (gnt_valid),
    .gnt_in    (gnt_in),
    .gnt_out   (gnt_out),
    .xbar_sel  (xbar_sel),
    .xbar_hold (xbar_hold),
    .ctl_valid (ctl_valid),
    .ctl_kind  (ctl_kind)
);

// File: tb/adaptive_input_ctrl_bench.sv
// Self-checking bench: a table of routing vectors, then directed tests.
module adaptive_input_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 3;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  hdr_valid;
    logic [14:0] hdr_dest_x, hdr_dest_y;
    logic [9:0]  hdr_kind;
    logic [4:0]  in_ready, hdr_pop;
    logic [3:0]  nbr_msg_valid;
    logic [7:0]  nbr_msg_kind;
    logic [7:0]  live_limit;
    logic        ctl_valid;
    logic [1:0]  ctl_kind;
    logic        gnt_valid;
    logic [2:0]  gnt_in, gnt_out;
    logic [14:0] xbar_sel;
    logic [4:0]  xbar_hold;

    int n_vec = 0;
    int n_bad = 0;
    logic [4:0] got;
    logic [2:0] got_out [5];
    logic [1:0] got_ctl [5];
    logic [4:0] got_hold [5];
    logic [2:0] got_sel [5];

    // Fields: port, dest x, dest y, expected output (router at 2,2).
    localparam logic [11:0] VEC [8] = '{
        {3'd4, 3'd4, 3'd2, 3'd1},
        {3'd0, 3'd0, 3'd2, 3'd3},
        {3'd1, 3'd2, 3'd4, 3'd0},
        {3'd2, 3'd2, 3'd0, 3'd2},
        {3'd3, 3'd2, 3'd2, 3'd4},
        {3'd4, 3'd5, 3'd5, 3'd1},
        {3'd0, 3'd0, 3'd0, 3'd3},
        {3'd2, 3'd3, 3'd0, 3'd1}
    };

    adaptive_input_ctrl #(.COORD_W(CW), .MY_X(2), .MY_Y(2), .TMO_W(8)) u_adaptive_input_ctrl (
        .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_dest_x(hdr_dest_x),
        .hdr_dest_y(hdr_dest_y), .hdr_kind(hdr_kind), .in_ready(in_ready),
        .hdr_pop(hdr_pop), .nbr_msg_valid(nbr_msg_valid), .nbr_msg_kind(nbr_msg_kind),
        .live_limit(live_limit), .ctl_valid(ctl_valid), .ctl_kind(ctl_kind),
        .gnt_valid(gnt_valid), .gnt_in(gnt_in), .gnt_out(gnt_out),
        .xbar_sel(xbar_sel), .xbar_hold(xbar_hold)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Advance to the next falling edge and record any pops.
    task automatic poll();
        @(negedge clk);
        for (int j = 0; j < 5; j++) begin
            if (hdr_pop[j]) begin
                got[j]         = 1'b1;
                got_out[j]     = gnt_out;
                got_ctl[j]     = ctl_kind;
                got_hold[j]    = xbar_hold;
                got_sel[j]     = xbar_sel[gnt_out*3 +: 3];
                hdr_valid[j]   = 1'b0;
            end
        end
    endtask

    task automatic present(input int p, input int x, input int y, input int k);
        hdr_dest_x[p*CW +: CW] = 3'(x);
        hdr_dest_y[p*CW +: CW] = 3'(y);
        hdr_kind[p*2 +: 2]     = 2'(k);
        got[p]                 = 1'b0;
        hdr_valid[p]           = 1'b1;
    endtask

    task automatic wait_pop(input int p, input int max);
        for (int c = 0; c < max && !got[p]; c++) poll();
    endtask

    task automatic nbr_msg(input int d, input int k);
        nbr_msg_kind[d*2 +: 2] = 2'(k);
        poll();
        nbr_msg_kind[d*2 +: 2] = 2'd0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : main
        rst_n = 1'b0; hdr_valid = '0; hdr_dest_x = '0; hdr_dest_y = '0; hdr_kind = '0;
        nbr_msg_valid = 4'hF; nbr_msg_kind = '0; live_limit = 8'd20; got = '0;
        repeat (3) @(negedge clk);
        // R10 reset state
        check(in_ready == 5'h1F, "R10 in_ready", in_ready, 31);
        check(hdr_pop == 0 && !gnt_valid, "R10 no grant", hdr_pop, 0);
        check(xbar_hold == 0 && !ctl_valid, "R10 hold/ctl", {xbar_hold, ctl_valid}, 0);
        rst_n = 1'b1;
        poll();
        check(ctl_valid && ctl_kind == 2'd0, "R10 heartbeat", {ctl_valid, ctl_kind}, 4);

        // R1 R2 routing table walk
        for (int v = 0; v < 8; v++) begin
            present(int'(VEC[v][11:9]), int'(VEC[v][8:6]), int'(VEC[v][5:3]), 0);
            wait_pop(int'(VEC[v][11:9]), 12);
            check(got[VEC[v][11:9]] == 1'b1, "R2 popped", got[VEC[v][11:9]], 1);
            check(got_out[VEC[v][11:9]] == VEC[v][2:0], "R1 output",
                  got_out[VEC[v][11:9]], VEC[v][2:0]);
            check(got_sel[VEC[v][11:9]] == VEC[v][11:9], "R2 xbar_sel",
                  got_sel[VEC[v][11:9]], VEC[v][11:9]);
        end

        // R6 R8: east reserved by neighbour, reroute north; release restores east
        nbr_msg(1, 1);
        present(4, 4, 4, 0); wait_pop(4, 12);
        check(got[4] && got_out[4] == 3'd0, "R8 reroute north", got_out[4], 0);
        nbr_msg(1, 2);
        present(4, 4, 4, 0); wait_pop(4, 12);
        check(got[4] && got_out[4] == 3'd1, "R6 release restores east", got_out[4], 1);

        // R9: only productive direction excluded -> hold and drop ready
        nbr_msg(1, 1);
        present(4, 4, 2, 0); wait_pop(4, 10);
        check(!got[4], "R9 no pop while blocked", got[4], 0);
        check(in_ready[4] == 1'b0, "R9 ready low", in_ready[4], 0);
        nbr_msg(1, 2);
        wait_pop(4, 12);
        check(got[4] && got_out[4] == 3'd1, "R9 granted after release", got_out[4], 1);
        poll();
        check(in_ready[4] == 1'b1, "R9 ready restored", in_ready[4], 1);

        // R3 R4 R5: circuit pin, owner reuse, foreign block, unpin
        present(4, 4, 2, 1); wait_pop(4, 12);
        check(got[4] && got_out[4] == 3'd1, "R3 circuit output", got_out[4], 1);
        check(got_hold[4][1] == 1'b1, "R3 hold set", got_hold[4][1], 1);
        check(got_ctl[4] == 2'd1, "R3 reserve sent", got_ctl[4], 1);
        present(0, 4, 2, 0); wait_pop(0, 10);
        check(!got[0], "R4 foreign input blocked", got[0], 0);
        check(in_ready[0] == 1'b0, "R4 foreign ready low", in_ready[0], 0);
        present(4, 4, 2, 0); wait_pop(4, 12);
        check(got[4] && got_out[4] == 3'd1, "R4 owner reuses pin", got_out[4], 1);
        check(!got[0], "R4 still blocked", got[0], 0);
        present(4, 4, 2, 2); wait_pop(4, 12);
        check(got[4] && got_ctl[4] == 2'd2, "R5 release sent", got_ctl[4], 2);
        check(got_hold[4][1] == 1'b0, "R5 hold cleared", got_hold[4][1], 0);
        wait_pop(0, 12);
        check(got[0] && got_out[0] == 3'd1, "R5 output freed", got_out[0], 1);

        // R7: silent east neighbour is dropped, then restored
        live_limit = 8'd4;
        nbr_msg_valid[1] = 1'b0;
        repeat (8) poll();
        present(4, 4, 4, 0); wait_pop(4, 12);
        check(got[4] && got_out[4] == 3'd0, "R7 silent neighbour dropped", got_out[4], 0);
        nbr_msg_valid[1] = 1'b1;
        repeat (2) poll();
        present(4, 4, 4, 0); wait_pop(4, 12);
        check(got[4] && got_out[4] == 3'd1, "R7 neighbour restored", got_out[4], 1);
        live_limit = 8'd20;

        // R6 same-cycle: reserve arrives in the visit of port 4
        present(4, 2, 2, 0); wait_pop(4, 12);
        repeat (4) poll();
        nbr_msg_kind[3:2] = 2'd1;
        present(4, 4, 4, 0);
        poll();
        nbr_msg_kind[3:2] = 2'd0;
        check(got[4] == 1'b1, "R2 visit every five cycles", got[4], 1);
        check(got_out[4] == 3'd0, "R6 same-cycle reserve honoured", got_out[4], 0);
        nbr_msg(1, 2);
        present(4, 4, 4, 0); wait_pop(4, 12);
        check(got[4] && got_out[4] == 3'd1, "R6 east back", got_out[4], 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule